// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating dual-slope converter. After a start request it closes the input switch for a fixed run-up window of 2^N clocks. It then opens that switch, closes the negative-reference switch, and counts clocks until the comparator reports that the integrator output has returned to zero. The count is the conversion result. Because the run-up length is fixed, the count is set only by the ratio of input to reference, so the integrator resistor and capacitor values drop out. A small input slope gives a short run-down, so conversion time depends on the input.

The comparator is asynchronous to the clock and passes through a two-stage synchronizer. The counter removes the two cycles of extra run-down that this adds. A run-down that reaches the full-scale count, or that does not end in time, is saturated to all ones and flagged as over range. The integrator, comparator and switches are analog parts outside this block.

Top module: `dsadc_seq`

## Requirements
- R1: While reset (active-low) is asserted and after it is released, both switch enables, `done`, `result` and `overRange` are 0.
- R2: A `start` pulse seen in the idle state raises `inSwEn` in the next cycle. `inSwEn` then stays high for exactly 2^RES_BITS consecutive cycles.
- R3: `refSwEn` rises in the cycle right after `inSwEn` falls, and the two enables are never high in the same cycle.
- R4: Let c be the number of `refSwEn` cycles before the run-down is closed. When the synchronized comparator trips, c equals the true zero-crossing count plus 2, and `result` = c - 2, with a floor of 0. In the bench model the true zero-crossing count is the input code.
- R5: `done` is high for exactly one cycle. `result` and `overRange` take their new values in that same cycle. Both switch enables are low while `done` is high and in the cycle after it.
- R6: If the comparator is already low when run-down begins (zero input), run-down lasts one cycle and `result` is 0 without over range.
- R7: A compensated count of 2^RES_BITS or more gives `result` all ones and `overRange` = 1. A smaller count gives `overRange` = 0. `overRange` high always implies `result` all ones.
- R8: If the comparator has not tripped after 2^RES_BITS+1 compensated run-down clocks, the sequencer stops. Run-down then lasts exactly 2^RES_BITS+4 cycles, and the result saturates with `overRange` = 1.
- R9: `start` is ignored while a conversion is in progress and in the `done` cycle. A pulse in those cycles neither lengthens the run-up nor starts a new conversion.
- R10: The comparator is ignored outside run-down. A low comparator level during run-up does not shorten run-up or change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, acted on only when idle |
| cmpHigh | input | 1 | Comparator, 1 while the integrator output is above zero (asynchronous) |
| inSwEn | output | 1 | Closes the input switch (run-up) |
| refSwEn | output | 1 | Closes the negative-reference switch (run-down) |
| result | output | RES_BITS | Latched conversion count |
| done | output | 1 | One-cycle pulse with a fresh result |
| overRange | output | 1 | Latched with result; count did not fit |

## Verification
Two events can coincide in one run-down cycle: the synchronized comparator trip and the run-down time limit. An input of 2^RES_BITS+1 codes makes the bench integrator cross zero so that the trip reaches the controller in exactly the cycle where the limit is hit. The bench expects one clean stop with a saturated result, `overRange` set, and a run-down of 2^RES_BITS+4 cycles. A second collision pairs a `start` pulse with the `done` cycle. It is judged by checking that no switch closes in the cycles that follow.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUNUP,
    ST_RUNDOWN,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic latch;
  } dpCtl_t;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmpSync,
  input  logic      runupLast,
  input  logic      rundownLimit,
  output seqState_t state,
  output dpCtl_t    ctl
);

  seqState_t stateNext;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext  = ST_RUNUP;
          ctl.cntClr = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (runupLast) begin
          stateNext  = ST_RUNDOWN;
          ctl.cntClr = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_RUNDOWN: begin
        if (!cmpSync || rundownLimit) begin
          stateNext = ST_FINISH;
          ctl.latch = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  output logic                runupLast,
  output logic                rundownLimit,
  output logic [RES_BITS-1:0] result,
  output logic                overRange
);

  localparam int CW         = RES_BITS + 2;
  localparam int LOAD_LEN   = 1 << RES_BITS;
  localparam int RUNUP_LAST = LOAD_LEN - 1;
  localparam int FULL_RAW   = LOAD_LEN + SYNC_STAGES;
  localparam int LIMIT_RAW  = LOAD_LEN + 1 + SYNC_STAGES;

  logic [CW-1:0] cnt;
  logic [CW-1:0] compCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + 1'b1;
  end

  assign runupLast    = (cnt == CW'(RUNUP_LAST));
  assign rundownLimit = (cnt == CW'(LIMIT_RAW));
  assign compCnt      = cnt - CW'(SYNC_STAGES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      overRange <= 1'b0;
    end else if (ctl.latch) begin
      if (cnt <= CW'(SYNC_STAGES)) begin
        result    <= '0;
        overRange <= 1'b0;
      end else if (cnt >= CW'(FULL_RAW)) begin
        result    <= '1;
        overRange <= 1'b1;
      end else begin
        result    <= compCnt[RES_BITS-1:0];
        overRange <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                cmpHigh,
  output logic                inSwEn,
  output logic                refSwEn,
  output logic [RES_BITS-1:0] result,
  output logic                done,
  output logic                overRange
);

  localparam int SYNC_STAGES = 2;

  seqState_t state;
  dpCtl_t    ctl;
  logic      cmpSync;
  logic      runupLast;
  logic      rundownLimit;

  dsadc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (cmpHigh),
    .syncOut (cmpSync)
  );

  dsadc_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .cmpSync      (cmpSync),
    .runupLast    (runupLast),
    .rundownLimit (rundownLimit),
    .state        (state),
    .ctl          (ctl)
  );

  dsadc_datapath #(.RES_BITS(RES_BITS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .runupLast    (runupLast),
    .rundownLimit (rundownLimit),
    .result       (result),
    .overRange    (overRange)
  );

  assign inSwEn  = (state == ST_RUNUP);
  assign refSwEn = (state == ST_RUNDOWN);
  assign done    = (state == ST_FINISH);

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                cmpHigh,
  input logic                inSwEn,
  input logic                refSwEn,
  input logic [RES_BITS-1:0] result,
  input logic                done,
  input logic                overRange
);

  localparam int LOAD_LEN = 1 << RES_BITS;
  localparam int REF_MAX  = LOAD_LEN + 4;

  int inRun;
  int refRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inRun  <= 0;
      refRun <= 0;
    end else begin
      inRun  <= inSwEn  ? inRun + 1  : 0;
      refRun <= refSwEn ? refRun + 1 : 0;
    end
  end

  a_r2_start_launch: assert property (@(posedge clk) disable iff (!rstN)
    (start && !inSwEn && !refSwEn && !done) |=> inSwEn);

  a_r2_runup_length: assert property (@(posedge clk) disable iff (!rstN)
    (!inSwEn && inRun != 0) |-> (inRun == LOAD_LEN));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(inSwEn && refSwEn));

  a_r3_ref_follows: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSwEn) |-> refSwEn);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_switches_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!inSwEn && !refSwEn));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  a_r7_ovr_ones: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (result == '1));

  a_r8_rundown_bound: assert property (@(posedge clk) disable iff (!rstN)
    refRun <= REF_MAX);

endmodule

bind dsadc_seq dsadc_seq_chk #(.RES_BITS(RES_BITS)) uChk (.*);

// File: tb/dsadc_seq_test.sv
module dsadc_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 8;
  localparam int LOAD_LEN   = 1 << RES_BITS;
  localparam int NVEC       = 8;
  localparam int VEC_IN  [NVEC] = '{0, 1, 2, 100, 255, 256, 257, 600};
  localparam int VEC_RES [NVEC] = '{0, 1, 2, 100, 255, 255, 255, 255};
  localparam bit VEC_OVR [NVEC] = '{0, 0, 0, 0,   0,   1,   1,   1};

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic                cmpHigh;
  logic                inSwEn;
  logic                refSwEn;
  logic [RES_BITS-1:0] result;
  logic                done;
  logic                overRange;

  int  errors = 0;
  int  checks = 0;
  longint acc = 0;
  int  vinCur = 0;
  bit  forceLow = 1'b0;
  int  cycleCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsadc_seq #(.RES_BITS(RES_BITS)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cmpHigh(cmpHigh),
    .inSwEn(inSwEn), .refSwEn(refSwEn), .result(result),
    .done(done), .overRange(overRange)
  );

  // behavioural integrator and comparator
  always @(posedge clk) begin
    if (inSwEn)       acc <= acc + vinCur;
    else if (refSwEn) acc <= acc - LOAD_LEN;
    else              acc <= 0;
  end
  assign cmpHigh = forceLow ? 1'b0 : (acc > 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRef(input int vin);
    if (vin == 0)                 return 1;
    else if (vin <= LOAD_LEN + 1) return vin + 3;
    else                          return LOAD_LEN + 4;
  endfunction

  task automatic runConv(input int vin, input int expRes, input bit expOvr,
                         input int glitchAt, input int busyAt, input bit startOnDone,
                         input string tag);
    int inCnt = 0;
    int refCnt = 0;
    int ovl = 0;
    int cyc = 0;
    bit gotDone = 0;
    int gotRes = 0;
    bit gotOvr = 0;
    vinCur = vin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!gotDone && cyc < 5000) begin
      if (inSwEn) inCnt++;
      if (refSwEn) refCnt++;
      if (inSwEn && refSwEn) ovl++;
      if (done) begin
        gotDone = 1;
        gotRes  = int'(result);
        gotOvr  = overRange;
      end
      start    = (cyc == busyAt) || (done && startOnDone);
      forceLow = (cyc >= glitchAt) && (cyc < glitchAt + 3);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    forceLow = 1'b0;
    check(gotDone, {tag, " R5 done seen"}, gotDone, 1);
    check(inCnt == LOAD_LEN, {tag, " R2 run-up length"}, inCnt, LOAD_LEN);
    check(ovl == 0, {tag, " R3 switch overlap"}, ovl, 0);
    check(refCnt == expRef(vin), {tag, " R8 run-down length"}, refCnt, expRef(vin));
    check(gotRes == expRes, {tag, " R4 result"}, gotRes, expRes);
    check(gotOvr == expOvr, {tag, " R7 over range"}, int'(gotOvr), int'(expOvr));
    check(!done && !inSwEn && !refSwEn, {tag, " R5 after done"},
          int'({done, inSwEn, refSwEn}), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!inSwEn && !refSwEn, {tag, " R9 stays idle"}, int'({inSwEn, refSwEn}), 0);
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!inSwEn && !refSwEn && !done, "R1 outputs in reset",
          int'({inSwEn, refSwEn, done}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(result == 0 && !overRange, "R1 result after reset", int'(result), 0);
    check(!inSwEn && !refSwEn && !done, "R1 idle after reset",
          int'({inSwEn, refSwEn, done}), 0);

    for (int v = 0; v < NVEC; v++) begin
      runConv(VEC_IN[v], VEC_RES[v], VEC_OVR[v], -10, -10, 1'b0, $sformatf("vec%0d", v));
    end

    // R6 zero input
    runConv(0, 0, 1'b0, -10, -10, 1'b0, "R6 zero");
    // R9 start while busy and start in done cycle
    runConv(37, 37, 1'b0, -10, 20, 1'b1, "R9 busy");
    // R10 comparator low during run-up
    runConv(77, 77, 1'b0, 60, -10, 1'b0, "R10 glitch");
    // trip and time limit in the same cycle (R8, R7)
    runConv(LOAD_LEN + 1, 255, 1'b1, -10, -10, 1'b0, "R8 collide");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycleCount, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule